// File: doc/BRIEF.md
# Priority interrupt recognition unit

This block sits between seven interrupt request lines and a processor core. Each line is active-low and level-sensitive, and it stands for one priority level from 1 (lowest) to 7 (highest). The block brings the lines into the clock domain and picks the most urgent pending level. It compares that level against the 3-bit priority mask held by the core. When the request passes, the block raises an interrupt-pending output and names the level. Level 7 cannot be masked.

When the core runs an acknowledge cycle it presents the level it is serving. The block answers one cycle later with the mask value the core must write back, which is the serviced level itself. It also returns a vector number. The vector is either an automatic one (a fixed base plus the level) or a number supplied by the requesting device, and a per-level enable bit picks between the two. A byte offset into the 512-byte vector table of 16-bit entries comes with it. A held level-7 request is serviced once only. It becomes eligible again after its line has gone high and then low.

Top module: `prio_irq_unit`

## Requirements
- R1: After synchronous reset, intr_o, intr_lvl_o, ack_valid_o, new_mask_o, vec_num_o and vec_off_o are all zero.
- R2: A request line that falls low just after a rising edge, on an otherwise idle unit with mask 0, shows on intr_o after the third following rising edge and not before: two synchronizer flops plus the output register.
- R3: For levels 1 to 6, a pending level less than or equal to mask_i is not recognized, and intr_o stays low.
- R4: With mask_i = 0, any pending level from 1 to 7 is recognized.
- R5: A pending level-7 request is recognized for every mask value, 7 included.
- R6: intr_lvl_o carries the highest pending level while intr_o is high. Line irq_n_i[k] is level k+1. intr_lvl_o is 0 whenever intr_o is low.
- R7: No request is recognized in the cycle that follows an acknowledge strobe. intr_o is low one edge after an edge at which iack_i was high.
- R8: An acknowledge with a nonzero iack_lvl_i produces ack_valid_o high for exactly the next cycle, with new_mask_o equal to the acknowledged level.
- R9: On an acknowledge of level L (1..7), vec_num_o is AUTO_BASE + L (default base 24) when auto_en_i[L-1] is 1, and ext_vec_i otherwise. An acknowledge with level 0 is ignored and ack_valid_o stays low.
- R10: vec_off_o equals twice vec_num_o, so it is always even and below 512.
- R11: After an acknowledge of level 7, a level-7 line that stays low is not recognized again. It is recognized again once the line has been high for at least three cycles and then goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n_i | input | 7 | Active-low request lines, bit k is level k+1 |
| mask_i | input | 3 | Current priority mask from the core |
| auto_en_i | input | 7 | Per-level automatic vector enable, bit k is level k+1 |
| ext_vec_i | input | VEC_W | Vector number supplied by the requesting device |
| iack_i | input | 1 | Acknowledge strobe, one cycle |
| iack_lvl_i | input | 3 | Level being acknowledged |
| intr_o | output | 1 | Interrupt pending for the core |
| intr_lvl_o | output | 3 | Level of the pending interrupt |
| ack_valid_o | output | 1 | Acknowledge answer valid |
| new_mask_o | output | 3 | Mask value to write back |
| vec_num_o | output | VEC_W | Vector number |
| vec_off_o | output | VEC_W+1 | Byte offset of the vector table entry |

## Verification
The bench targets the boundary where the level equals the mask. A comparison written with the wrong inclusivity would recognize level 6 under mask 6 or drop level 6 under mask 5. It also drives level 7 under the maximum mask, which a design without the unmaskable exception would silently ignore. A level-7 line is held low through its acknowledge to catch a unit that would re-raise the same request forever. Random patterns across all mask values, together with random acknowledges with mixed automatic enables, expose wrong priority ordering, a wrong vector source, a doubled offset error and a level-0 acknowledge that is wrongly answered.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 7;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/pir_sync.sv
module pir_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pir_prio_enc.sv
module pir_prio_enc #(
  parameter int N  = 7,
  parameter int OW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [OW-1:0] lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) lvl_o = OW'(i + 1);
    end
  end
endmodule

// File: rtl/pir_recog.sv
module pir_recog
  import pir_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] req_i,
  input  lvl_t               mask_i,
  input  logic               iack_i,
  input  lvl_t               iack_lvl_i,
  output logic               intr_o,
  output lvl_t               intr_lvl_o
);
  localparam lvl_t TOP_LVL = lvl_t'(NUM_LVL);

  logic               arm_q;
  logic [NUM_LVL-1:0] eff_req;
  lvl_t               top_lvl;
  logic               accept;

  // the top level only counts while armed by a high phase of its line
  assign eff_req = {req_i[NUM_LVL-1] & arm_q, req_i[NUM_LVL-2:0]};

  pir_prio_enc #(.N(NUM_LVL), .OW(LVL_W)) u_enc (
    .req_i (eff_req),
    .lvl_o (top_lvl)
  );

  assign accept = (top_lvl != '0) && ((top_lvl == TOP_LVL) || (top_lvl > mask_i)) && !iack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b1;
    end else if (iack_i && iack_lvl_i == TOP_LVL) begin
      arm_q <= 1'b0;
    end else if (!req_i[NUM_LVL-1]) begin
      arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intr_o     <= 1'b0;
      intr_lvl_o <= '0;
    end else begin
      intr_o     <= accept;
      intr_lvl_o <= accept ? top_lvl : '0;
    end
  end

  AST_MASK_RESPECTED: assert property (@(posedge clk) disable iff (rst)
    (intr_o && intr_lvl_o != TOP_LVL) |-> (intr_lvl_o > $past(mask_i))); // R3
  AST_QUIET_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    iack_i |=> !intr_o); // R7
  AST_LVL_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !intr_o |-> (intr_lvl_o == '0)); // R6
  AST_TOP_ONCE: assert property (@(posedge clk) disable iff (rst)
    (iack_i && iack_lvl_i == TOP_LVL) |=> ##1 (intr_lvl_o != TOP_LVL)); // R11
endmodule

// File: rtl/pir_vector.sv
module pir_vector
  import pir_pkg::*;
#(
  parameter int             VEC_W     = 8,
  parameter logic [VEC_W-1:0] AUTO_BASE = 8'd24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               iack_i,
  input  lvl_t               iack_lvl_i,
  input  logic [NUM_LVL-1:0] auto_en_i,
  input  logic [VEC_W-1:0]   ext_vec_i,
  output logic               ack_valid_o,
  output lvl_t               new_mask_o,
  output logic [VEC_W-1:0]   vec_num_o,
  output logic [VEC_W:0]     vec_off_o
);
  logic                 lvl_ok;
  logic [NUM_LVL:0]     auto_ext;
  logic                 use_auto;
  logic [VEC_W-1:0]     vec_next;

  assign lvl_ok   = iack_i && (iack_lvl_i != '0);
  assign auto_ext = {auto_en_i, 1'b0};
  assign use_auto = auto_ext[iack_lvl_i];
  assign vec_next = use_auto ? (AUTO_BASE + VEC_W'(iack_lvl_i)) : ext_vec_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid_o <= 1'b0;
      new_mask_o  <= '0;
      vec_num_o   <= '0;
      vec_off_o   <= '0;
    end else begin
      ack_valid_o <= lvl_ok;
      if (lvl_ok) begin
        new_mask_o <= iack_lvl_i;
        vec_num_o  <= vec_next;
        vec_off_o  <= {vec_next, 1'b0};
      end
    end
  end

  AST_ACK_ANSWER: assert property (@(posedge clk) disable iff (rst)
    (iack_i && iack_lvl_i != '0) |=> (ack_valid_o && new_mask_o == $past(iack_lvl_i))); // R8
  AST_ACK_LVL0_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !(iack_i && iack_lvl_i != '0) |=> !ack_valid_o); // R9
  AST_AUTO_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (iack_i && iack_lvl_i != '0 && use_auto) |=> (vec_num_o == AUTO_BASE + VEC_W'($past(iack_lvl_i)))); // R9
  AST_OFFSET_EVEN: assert property (@(posedge clk) disable iff (rst)
    ack_valid_o |-> (vec_off_o[0] == 1'b0 && vec_off_o[VEC_W:1] == vec_num_o)); // R10
endmodule

// File: rtl/prio_irq_unit.sv
module prio_irq_unit
  import pir_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               VEC_W       = 8,
  parameter logic [VEC_W-1:0] AUTO_BASE   = 8'd24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [6:0]       irq_n_i,
  input  logic [2:0]       mask_i,
  input  logic [6:0]       auto_en_i,
  input  logic [VEC_W-1:0] ext_vec_i,
  input  logic             iack_i,
  input  logic [2:0]       iack_lvl_i,
  output logic             intr_o,
  output logic [2:0]       intr_lvl_o,
  output logic             ack_valid_o,
  output logic [2:0]       new_mask_o,
  output logic [VEC_W-1:0] vec_num_o,
  output logic [VEC_W:0]   vec_off_o
);
  logic [NUM_LVL-1:0] req_s;

  pir_sync #(.WIDTH(NUM_LVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (~irq_n_i),
    .q_o (req_s)
  );

  pir_recog u_recog (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_s),
    .mask_i     (mask_i),
    .iack_i     (iack_i),
    .iack_lvl_i (iack_lvl_i),
    .intr_o     (intr_o),
    .intr_lvl_o (intr_lvl_o)
  );

  pir_vector #(.VEC_W(VEC_W), .AUTO_BASE(AUTO_BASE)) u_vec (
    .clk         (clk),
    .rst         (rst),
    .iack_i      (iack_i),
    .iack_lvl_i  (iack_lvl_i),
    .auto_en_i   (auto_en_i),
    .ext_vec_i   (ext_vec_i),
    .ack_valid_o (ack_valid_o),
    .new_mask_o  (new_mask_o),
    .vec_num_o   (vec_num_o),
    .vec_off_o   (vec_off_o)
  );
endmodule

// File: tb/prio_irq_unit_tb.sv
module prio_irq_unit_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] irq_n;
  logic [2:0] mask;
  logic [6:0] auto_en;
  logic [7:0] ext_vec;
  logic       iack;
  logic [2:0] iack_lvl;
  logic       intr;
  logic [2:0] intr_lvl;
  logic       ack_valid;
  logic [2:0] new_mask;
  logic [7:0] vec_num;
  logic [8:0] vec_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  prio_irq_unit u_dut (
    .clk(clk), .rst(rst), .irq_n_i(irq_n), .mask_i(mask), .auto_en_i(auto_en),
    .ext_vec_i(ext_vec), .iack_i(iack), .iack_lvl_i(iack_lvl), .intr_o(intr),
    .intr_lvl_o(intr_lvl), .ack_valid_o(ack_valid), .new_mask_o(new_mask),
    .vec_num_o(vec_num), .vec_off_o(vec_off)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_lvl(input logic [6:0] req, input int m);
    int h = 0;
    for (int i = 0; i < 7; i++) if (req[i]) h = i + 1;
    if (h != 0 && (h == 7 || h > m)) return h;
    return 0;
  endfunction

  function automatic int model_vec(input int lvl, input logic [6:0] en, input int ext);
    if (en[lvl-1]) return 24 + lvl;
    return ext;
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_lines();
    irq_n = 7'h7f;
    cycles(5);
  endtask

  task automatic do_ack(input int lvl, input logic [6:0] en, input int ext);
    iack = 1'b1; iack_lvl = 3'(lvl); auto_en = en; ext_vec = 8'(ext);
    cycles(1);
    iack = 1'b0;
    chk("R7 intr low after ack", int'(intr), 0);
    chk("R8/R9 ack_valid", int'(ack_valid), (lvl != 0) ? 1 : 0);
    if (lvl != 0) begin
      chk("R8 new_mask", int'(new_mask), lvl);
      chk("R9 vector", int'(vec_num), model_vec(lvl, en, ext));
      chk("R10 offset", int'(vec_off), 2 * model_vec(lvl, en, ext));
    end
    cycles(1);
    chk("R8 ack_valid one cycle", int'(ack_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; irq_n = 7'h7f; mask = 3'd0; auto_en = '0; ext_vec = '0;
    iack = 1'b0; iack_lvl = '0;
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 intr", int'(intr), 0);
    chk("R1 intr_lvl", int'(intr_lvl), 0);
    chk("R1 ack_valid", int'(ack_valid), 0);
    chk("R1 new_mask", int'(new_mask), 0);
    chk("R1 vec_num", int'(vec_num), 0);
    chk("R1 vec_off", int'(vec_off), 0);

    // R2 latency
    idle_lines();
    mask = 3'd0;
    irq_n = 7'b1111011;
    cycles(2);
    chk("R2 not yet", int'(intr), 0);
    cycles(1);
    chk("R2 visible", int'(intr), 1);
    chk("R2 level", int'(intr_lvl), 3);

    // R3 boundary
    idle_lines(); mask = 3'd6; irq_n = 7'b1011111; cycles(5);
    chk("R3 lvl6 mask6", int'(intr), 0);
    mask = 3'd5; cycles(2);
    chk("R3 lvl6 mask5", int'(intr_lvl), 6);
    idle_lines(); mask = 3'd7; irq_n = 7'b1011111; cycles(5);
    chk("R3 lvl6 mask7", int'(intr), 0);

    // R4 lowest level with mask 0
    idle_lines(); mask = 3'd0; irq_n = 7'b1111110; cycles(5);
    chk("R4 lvl1 mask0", int'(intr_lvl), 1);

    // R5 unmaskable top
    idle_lines(); mask = 3'd7; irq_n = 7'b0111111; cycles(5);
    chk("R5 lvl7 mask7", int'(intr), 1);
    chk("R5 lvl7 level", int'(intr_lvl), 7);

    // R6 priority with many lines
    idle_lines(); mask = 3'd0; irq_n = 7'b1010110; cycles(5);
    chk("R6 highest of 6,4,1", int'(intr_lvl), 6);
    idle_lines();
    chk("R6 none pending", int'(intr_lvl), 0);

    // R9 level-0 ack ignored
    do_ack(0, 7'h7f, 8'd99);

    // R11 held top level served once
    idle_lines(); mask = 3'd0; irq_n = 7'b0111111; cycles(5);
    chk("R11 first service", int'(intr_lvl), 7);
    do_ack(7, 7'h40, 8'd0);
    cycles(6);
    chk("R11 held line not re-raised", int'(intr), 0);
    irq_n = 7'h7f; cycles(4);
    irq_n = 7'b0111111; cycles(5);
    chk("R11 re-raised after high phase", int'(intr_lvl), 7);

    // random patterns
    for (int n = 0; n < 300; n++) begin
      logic [6:0] req;
      int m, al, ev;
      logic [6:0] en;
      idle_lines();
      req = 7'($urandom);
      m = int'($urandom % 8);
      mask = 3'(m);
      irq_n = ~req;
      cycles(5);
      chk("R6 random intr", int'(intr), (model_lvl(req, m) != 0) ? 1 : 0);
      chk("R3/R4/R5/R6 random level", int'(intr_lvl), model_lvl(req, m));
      al = int'($urandom % 8);
      en = 7'($urandom);
      ev = int'($urandom % 256);
      do_ack(al, en, ev);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule